// File: doc/BRIEF.md
# Sub-word Video Add Unit

This unit adds two 32-bit sources after pulling a byte, a halfword or the full word out of each one and widening it. Each source has its own signedness bit and its own negate bit. The sum is formed at a width that cannot overflow. It can then be clamped to the 32-bit range of the chosen result type. A second stage combines the sum with a third register. That stage can write the sum into one half or one byte of the third register, add it to the register, take the smaller or larger of the two, or pass the sum through unchanged.

The unit sits after an instruction decoder and a register read stage. Those stages supply the three register values and the already decoded control fields. An operation is presented for one cycle with `inValid` high. The result appears on the next cycle with `outValid` high. The second source can be taken from a 16-bit immediate field instead of a register, in which case its low byte is used.

Top module: `vaddSubword`

## Requirements
- R1: The 3-bit field selector `selA`/`selB` picks the operand field as follows: 0 to 3 pick byte 0 to byte 3 (byte k is bits 8k+7..8k), 4 picks bits 15..0, 5 picks bits 31..16, and 6 picks the whole word.
- R2: The selected field is zero-extended when its type bit (`signA`/`signB`) is 0 and sign-extended when it is 1.
- R3: When `useImm` is 1, the second operand is bits 7..0 of `immB`, extended according to `signB`. `selB` and `srcB` have no effect in this case.
- R4: When `negA` (or `negB`) is 1, the extended first (or second) operand is negated before the addition. The sum is exact, with no wrap.
- R5: When `satEn` is 1, the exact sum is clamped. With `resSigned`=1 the range is -2^31 to 2^31-1. With `resSigned`=0 the range is 0 to 2^32-1. `satFlag` is 1 exactly when clamping changed the value.
- R6: When `satEn` is 0, the sum keeps its low 32 bits and `satFlag` is 0.
- R7: The merge codes of `postOp` take the sum S and the third register C. Code 0 gives {S[15:0], C[15:0]}. Code 1 gives {C[31:16], S[15:0]}. Code 2 gives {C[31:8], S[7:0]}. Code 3 gives {C[31:24], S[7:0], C[15:0]}.
- R8: `postOp` code 4 gives S + C modulo 2^32.
- R9: `postOp` code 5 gives the minimum of S and C, and code 6 gives the maximum. Both compare as signed when `resSigned`=1 and as unsigned when it is 0.
- R10: `postOp` code 7 passes S through unchanged.
- R11: Selector code 7 on `selA`, or on `selB` when `useImm` is 0, sets `invalidFlag`, forces the result to zero and clears `satFlag`.
- R12: Reset clears `outValid`, `result`, `invalidFlag` and `satFlag`. The outputs are updated on the clock edge after a cycle with `inValid` high, and `outValid` then shows 1 for that cycle only. With `inValid` low, the result and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation presented this cycle |
| srcA | input | 32 | First source register |
| srcB | input | 32 | Second source register |
| srcC | input | 32 | Third register used by the second stage |
| immB | input | 16 | Immediate used in place of the second source |
| useImm | input | 1 | Take the second operand from immB |
| selA | input | 3 | Field selector for the first operand |
| selB | input | 3 | Field selector for the second operand |
| signA | input | 1 | First operand signed |
| signB | input | 1 | Second operand signed |
| negA | input | 1 | Negate the first operand |
| negB | input | 1 | Negate the second operand |
| satEn | input | 1 | Clamp the sum to the result range |
| resSigned | input | 1 | Result type signed (1) or unsigned (0) |
| postOp | input | 3 | Second-stage operation code |
| outValid | output | 1 | Result registered from the previous cycle |
| result | output | 32 | Final result |
| invalidFlag | output | 1 | Selector code 7 was used |
| satFlag | output | 1 | Clamping changed the sum |

## Verification
The main stimulus is random. Source words are drawn so that byte and half lanes often carry a set top bit. Selectors, type bits, negate bits and the saturate and result-signedness controls are all random. Because of this, a wrong lane, a wrong extension or a missed negation shows up as a different sum.

Directed cases isolate particular behaviour. Walking one operation through each selector code on a word with distinct bytes identifies which field was taken. A negative byte run through both type settings separates zero extension from sign extension. Sums driven just past the positive and negative limits under both result types tell a signed clamp apart from an unsigned one. One value pair, 0xFFFFFFF0 against 5, gives opposite minimum and maximum answers under the signed and unsigned compares. Runs with `useImm` set carry junk on `srcB` and code 7 on `selB`, which shows that neither one is used. Idle cycles with changing inputs check that the registered result holds.

// File: rtl/vadd_pkg.sv
package vadd_pkg;

  typedef enum logic [1:0] {
    W_BYTE = 2'd0,
    W_HALF = 2'd1,
    W_WORD = 2'd2
  } widthT;

  typedef struct packed {
    widthT      width;
    logic [1:0] lane;
  } fieldSelT;

  typedef enum logic [2:0] {
    P_MERGE = 3'd0,
    P_ACC   = 3'd1,
    P_MIN   = 3'd2,
    P_MAX   = 3'd3,
    P_PASS  = 3'd4
  } postKindT;

  typedef struct packed {
    logic      load;
    logic      badSel;
    fieldSelT  fldA;
    fieldSelT  fldB;
    logic      useImm;
    postKindT  post;
    logic [4:0] mergeShift;
    logic [1:0] mergeSize;   // 0: byte, 1: half
  } vaddCtrlT;

endpackage

// File: rtl/vaddExtract.sv
module vaddExtract
  import vadd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXT_W  = DATA_W + 2
) (
  input  logic [DATA_W-1:0]        word,
  input  fieldSelT                 fld,
  input  logic                     isSigned,
  input  logic                     negate,
  output logic signed [EXT_W-1:0]  val
);
  localparam int HALF_W = DATA_W / 2;

  logic [7:0]            byteField;
  logic [HALF_W-1:0]     halfField;
  logic signed [EXT_W-1:0] widened;

  always_comb begin
    byteField = word[{3'b000, fld.lane} * 8 +: 8];
    halfField = fld.lane[0] ? word[DATA_W-1 -: HALF_W] : word[HALF_W-1:0];
    unique case (fld.width)
      W_BYTE:  widened = {{(EXT_W-8){isSigned & byteField[7]}}, byteField};
      W_HALF:  widened = {{(EXT_W-HALF_W){isSigned & halfField[HALF_W-1]}}, halfField};
      default: widened = {{(EXT_W-DATA_W){isSigned & word[DATA_W-1]}}, word};
    endcase
    val = negate ? -widened : widened;
  end
endmodule

// File: rtl/vaddCtrl.sv
module vaddCtrl
  import vadd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       useImm,
  input  logic [2:0] selA,
  input  logic [2:0] selB,
  input  logic [2:0] postOp,
  output vaddCtrlT   ctrl,
  output logic       outValid
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [4:0] HALF_SHIFT = 5'(HALF_W);

  function automatic fieldSelT decodeSel(input logic [2:0] code);
    fieldSelT f;
    f.lane = code[1:0];
    if (code[2] == 1'b0) begin
      f.width = W_BYTE;
    end else if (code[1] == 1'b0) begin
      f.width = W_HALF;
      f.lane  = {1'b0, code[0]};
    end else begin
      f.width = W_WORD;
      f.lane  = 2'd0;
    end
    return f;
  endfunction

  always_comb begin
    ctrl.load   = inValid;
    ctrl.useImm = useImm;
    ctrl.fldA   = decodeSel(selA);
    ctrl.fldB   = useImm ? fieldSelT'{width: W_BYTE, lane: 2'd0} : decodeSel(selB);
    ctrl.badSel = (selA == 3'd7) || (!useImm && selB == 3'd7);
    ctrl.mergeShift = 5'd0;
    ctrl.mergeSize  = 2'd0;
    unique case (postOp)
      3'd0: begin ctrl.post = P_MERGE; ctrl.mergeShift = HALF_SHIFT; ctrl.mergeSize = 2'd1; end
      3'd1: begin ctrl.post = P_MERGE; ctrl.mergeShift = 5'd0;       ctrl.mergeSize = 2'd1; end
      3'd2: begin ctrl.post = P_MERGE; ctrl.mergeShift = 5'd0;       ctrl.mergeSize = 2'd0; end
      3'd3: begin ctrl.post = P_MERGE; ctrl.mergeShift = HALF_SHIFT; ctrl.mergeSize = 2'd0; end
      3'd4: ctrl.post = P_ACC;
      3'd5: ctrl.post = P_MIN;
      3'd6: ctrl.post = P_MAX;
      default: ctrl.post = P_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/vaddDatapath.sv
module vaddDatapath
  import vadd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  vaddCtrlT          ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] srcC,
  input  logic [IMM_W-1:0]  immB,
  input  logic              signA,
  input  logic              signB,
  input  logic              negA,
  input  logic              negB,
  input  logic              satEn,
  input  logic              resSigned,
  output logic [DATA_W-1:0] result,
  output logic              invalidFlag,
  output logic              satFlag
);
  localparam int EXT_W  = DATA_W + 2;
  localparam int HALF_W = DATA_W / 2;
  localparam logic signed [EXT_W-1:0] S_MAX = {{(EXT_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] S_MIN = {{(EXT_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [EXT_W-1:0] U_MAX = {{(EXT_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};
  localparam logic signed [EXT_W-1:0] U_MIN = '0;
  localparam logic [DATA_W-1:0] BYTE_ONES = {{(DATA_W-8){1'b0}}, 8'hFF};
  localparam logic [DATA_W-1:0] HALF_ONES = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [DATA_W-1:0]       wordB;
  logic signed [EXT_W-1:0] opA, opB, rawSum, hiLim, loLim, clampSum;
  logic                    overHi, underLo, clampHit;
  logic [DATA_W-1:0]       sumWord, mergeMask, postVal;
  logic                    sumBelowC;
  logic [DATA_W-1:0]       nextResult;
  logic                    nextSat;

  assign wordB = ctrl.useImm ? {{(DATA_W-IMM_W){1'b0}}, immB} : srcB;

  vaddExtract #(.DATA_W(DATA_W), .EXT_W(EXT_W)) i_extA (
    .word(srcA), .fld(ctrl.fldA), .isSigned(signA), .negate(negA), .val(opA)
  );
  vaddExtract #(.DATA_W(DATA_W), .EXT_W(EXT_W)) i_extB (
    .word(wordB), .fld(ctrl.fldB), .isSigned(signB), .negate(negB), .val(opB)
  );

  always_comb begin
    rawSum   = opA + opB;
    hiLim    = resSigned ? S_MAX : U_MAX;
    loLim    = resSigned ? S_MIN : U_MIN;
    overHi   = rawSum > hiLim;
    underLo  = rawSum < loLim;
    clampHit = satEn && (overHi || underLo);
    if (satEn && overHi)       clampSum = hiLim;
    else if (satEn && underLo) clampSum = loLim;
    else                       clampSum = rawSum;
    sumWord  = clampSum[DATA_W-1:0];
  end

  always_comb begin
    mergeMask = (ctrl.mergeSize == 2'd1 ? HALF_ONES : BYTE_ONES) << ctrl.mergeShift;
    sumBelowC = resSigned ? ($signed(sumWord) < $signed(srcC)) : (sumWord < srcC);
    unique case (ctrl.post)
      P_MERGE: postVal = (srcC & ~mergeMask) | ((sumWord << ctrl.mergeShift) & mergeMask);
      P_ACC:   postVal = sumWord + srcC;
      P_MIN:   postVal = sumBelowC ? sumWord : srcC;
      P_MAX:   postVal = sumBelowC ? srcC : sumWord;
      default: postVal = sumWord;
    endcase
    nextResult = ctrl.badSel ? '0 : postVal;
    nextSat    = ctrl.badSel ? 1'b0 : clampHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      invalidFlag <= 1'b0;
      satFlag     <= 1'b0;
    end else if (ctrl.load) begin
      result      <= nextResult;
      invalidFlag <= ctrl.badSel;
      satFlag     <= nextSat;
    end
  end
endmodule

// File: rtl/vaddSubword.sv
module vaddSubword
  import vadd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] srcC,
  input  logic [IMM_W-1:0]  immB,
  input  logic              useImm,
  input  logic [2:0]        selA,
  input  logic [2:0]        selB,
  input  logic              signA,
  input  logic              signB,
  input  logic              negA,
  input  logic              negB,
  input  logic              satEn,
  input  logic              resSigned,
  input  logic [2:0]        postOp,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              invalidFlag,
  output logic              satFlag
);
  vaddCtrlT ctrl;

  vaddCtrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .useImm(useImm),
    .selA(selA), .selB(selB), .postOp(postOp), .ctrl(ctrl), .outValid(outValid)
  );

  vaddDatapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .srcA(srcA), .srcB(srcB), .srcC(srcC),
    .immB(immB), .signA(signA), .signB(signB), .negA(negA), .negB(negB),
    .satEn(satEn), .resSigned(resSigned), .result(result),
    .invalidFlag(invalidFlag), .satFlag(satFlag)
  );
endmodule

// File: rtl/vaddChecker.sv
module vaddChecker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] srcC,
  input logic              satEn,
  input logic              resSigned,
  input logic [2:0]        postOp,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              invalidFlag,
  input logic              satFlag
);
  // R12: one-cycle latency on the valid strobe
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r12_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R12: outputs hold while idle
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(invalidFlag) && $stable(satFlag)));
  // R11: invalid selector forces zero and no saturation
  a_r11_invalid_zero: assert property (@(posedge clk) disable iff (!rstN)
    invalidFlag |-> (result == '0 && !satFlag));
  // R5: unsigned clamp lands on a range limit
  a_r5_unsigned_limit: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && satEn && !resSigned && postOp == 3'd7) |=>
      (!satFlag || result == '0 || result == '1));
  // R6: no saturation flag without saturate enable
  a_r6_no_sat_flag: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !satEn) |=> !satFlag);
  // R7: merge into the high half keeps the low half of the third register
  a_r7_merge_keeps_low: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && postOp == 3'd0) |=> (invalidFlag || result[15:0] == $past(srcC[15:0])));
  // R9: signed minimum never exceeds the third register
  a_r9_min_bound: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && postOp == 3'd5 && resSigned) |=>
      (invalidFlag || $signed(result) <= $signed($past(srcC))));
endmodule

bind vaddSubword vaddChecker #(.DATA_W(DATA_W)) i_vaddChecker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .srcC(srcC), .satEn(satEn),
  .resSigned(resSigned), .postOp(postOp), .outValid(outValid), .result(result),
  .invalidFlag(invalidFlag), .satFlag(satFlag)
);

// File: tb/test_vaddSubword.sv
module test_vaddSubword;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] srcA = '0, srcB = '0, srcC = '0;
  logic [15:0] immB = '0;
  logic        useImm = 1'b0;
  logic [2:0]  selA = '0, selB = '0, postOp = 3'd7;
  logic        signA = 1'b0, signB = 1'b0, negA = 1'b0, negB = 1'b0;
  logic        satEn = 1'b0, resSigned = 1'b1;
  logic        outValid, invalidFlag, satFlag;
  logic [31:0] result;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vaddSubword i_vaddSubword (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB), .srcC(srcC),
    .immB(immB), .useImm(useImm), .selA(selA), .selB(selB), .signA(signA), .signB(signB),
    .negA(negA), .negB(negB), .satEn(satEn), .resSigned(resSigned), .postOp(postOp),
    .outValid(outValid), .result(result), .invalidFlag(invalidFlag), .satFlag(satFlag)
  );

  // Field value with extension and negation (R1, R2, R4)
  function automatic longint fieldOf(logic [31:0] w, logic [2:0] sel, bit sgn, bit neg);
    longint f;
    int bits;
    case (sel)
      3'd0, 3'd1, 3'd2, 3'd3: begin f = longint'((w >> (8 * sel)) & 32'hFF); bits = 8; end
      3'd4: begin f = longint'(w & 32'h0000_FFFF); bits = 16; end
      3'd5: begin f = longint'(w >> 16); bits = 16; end
      default: begin f = longint'(w); bits = 32; end
    endcase
    if (sgn && f[bits-1]) f = f - (longint'(1) << bits);
    return neg ? -f : f;
  endfunction

  function automatic void model(
    input logic [31:0] a, b, c, input logic [15:0] im, input bit imm,
    input logic [2:0] sa, sb, po, input bit sga, sgb, na, nb, sat, rs,
    output logic [31:0] r, output bit inv, output bit sf);
    longint opa, opb, s, hi, lo;
    logic [31:0] v;
    inv = (sa == 3'd7) || (!imm && sb == 3'd7);
    opa = fieldOf(a, sa, sga, na);
    opb = imm ? fieldOf({16'h0, im}, 3'd0, sgb, nb) : fieldOf(b, sb, sgb, nb);
    s = opa + opb;
    hi = rs ? 64'sd2147483647 : 64'sd4294967295;
    lo = rs ? -64'sd2147483648 : 64'sd0;
    sf = 1'b0;
    if (sat && s > hi) begin s = hi; sf = 1'b1; end
    if (sat && s < lo) begin s = lo; sf = 1'b1; end
    v = s[31:0];
    case (po)
      3'd0: r = {v[15:0], c[15:0]};
      3'd1: r = {c[31:16], v[15:0]};
      3'd2: r = {c[31:8], v[7:0]};
      3'd3: r = {c[31:24], v[7:0], c[15:0]};
      3'd4: r = v + c;
      3'd5: r = (rs ? ($signed(v) < $signed(c)) : (v < c)) ? v : c;
      3'd6: r = (rs ? ($signed(v) > $signed(c)) : (v > c)) ? v : c;
      default: r = v;
    endcase
    if (inv) begin r = '0; sf = 1'b0; end
  endfunction

  task automatic check(string tag, logic [31:0] er, bit ei, bit es, bit ev);
    nChecks++;
    if (result !== er || invalidFlag !== ei || satFlag !== es || outValid !== ev) begin
      nFails++;
      $display("FAIL %s: got r=%08h inv=%0b sat=%0b v=%0b, expected r=%08h inv=%0b sat=%0b v=%0b",
               tag, result, invalidFlag, satFlag, outValid, er, ei, es, ev);
    end
  endtask

  task automatic runOp(string tag, logic [31:0] a, b, c, logic [15:0] im, bit imm,
                       logic [2:0] sa, sb, po, bit sga, sgb, na, nb, sat, rs);
    logic [31:0] er;
    bit ei, es;
    @(negedge clk);
    srcA = a; srcB = b; srcC = c; immB = im; useImm = imm; selA = sa; selB = sb;
    postOp = po; signA = sga; signB = sgb; negA = na; negB = nb; satEn = sat; resSigned = rs;
    inValid = 1'b1;
    model(a, b, c, im, imm, sa, sb, po, sga, sgb, na, nb, sat, rs, er, ei, es);
    @(negedge clk);
    inValid = 1'b0;
    check(tag, er, ei, es, 1'b1);
  endtask

  task automatic idleCheck(string tag);
    logic [31:0] keepR;
    bit keepI, keepS;
    keepR = result; keepI = invalidFlag; keepS = satFlag;
    srcA = $urandom; srcB = $urandom; srcC = $urandom; selA = 3'($urandom);
    postOp = 3'($urandom); satEn = 1'($urandom);
    @(negedge clk);
    check(tag, keepR, keepI, keepS, 1'b0);
  endtask

  initial begin
    #2_000_000ns;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R12 reset state", 32'h0, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: every selector code on a word with distinct bytes
    for (int k = 0; k < 7; k++)
      runOp("R1 selector", 32'h8433_2211, 32'h0, 32'h0, 16'h0, 1'b0, 3'(k), 3'd6, 3'd7,
            1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R2: negative byte, zero vs sign extension
    runOp("R2 zero extend", 32'h0000_00F0, 32'h0, 32'h0, 16'h0, 1'b0, 3'd0, 3'd6, 3'd7,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    runOp("R2 sign extend", 32'h0000_00F0, 32'h0, 32'h0, 16'h0, 1'b0, 3'd0, 3'd6, 3'd7,
          1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R3: immediate with junk srcB and code 7 on selB
    runOp("R3 immediate", 32'd10, 32'hDEAD_BEEF, 32'h0, 16'h12FE, 1'b1, 3'd6, 3'd7, 3'd7,
          1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    runOp("R3 immediate unsigned", 32'd10, 32'h1234_5678, 32'h0, 16'h12FE, 1'b1, 3'd6, 3'd5, 3'd7,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R4: negation of each operand
    runOp("R4 negate A", 32'd7, 32'd3, 32'h0, 16'h0, 1'b0, 3'd6, 3'd6, 3'd7,
          1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    runOp("R4 negate B", 32'd7, 32'd30, 32'h0, 16'h0, 1'b0, 3'd6, 3'd6, 3'd7,
          1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    // R5: clamp limits both ways under both result types
    runOp("R5 signed high", 32'h7FFF_FFFF, 32'd1, 32'h0, 16'h0, 1'b0, 3'd6, 3'd6, 3'd7,
          1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    runOp("R5 signed low", 32'h8000_0000, 32'd1, 32'h0, 16'h0, 1'b0, 3'd6, 3'd6, 3'd7,
          1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    runOp("R5 unsigned high", 32'hFFFF_FFFF, 32'd2, 32'h0, 16'h0, 1'b0, 3'd6, 3'd6, 3'd7,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    runOp("R5 unsigned low", 32'd1, 32'd2, 32'h0, 16'h0, 1'b0, 3'd6, 3'd6, 3'd7,
          1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    // R6: wrap without saturation
    runOp("R6 wrap", 32'h7FFF_FFFF, 32'd1, 32'h0, 16'h0, 1'b0, 3'd6, 3'd6, 3'd7,
          1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    // R7: the four merges
    for (int m = 0; m < 4; m++)
      runOp("R7 merge", 32'h0000_ABCD, 32'h0000_0011, 32'h5566_7788, 16'h0, 1'b0, 3'd6, 3'd6, 3'(m),
            1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R8: accumulate with wrap
    runOp("R8 accumulate", 32'hFFFF_FFF0, 32'd0, 32'h0000_0020, 16'h0, 1'b0, 3'd6, 3'd6, 3'd4,
          1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    // R9: min/max differ between signed and unsigned
    for (int s = 0; s < 2; s++) begin
      runOp("R9 min", 32'hFFFF_FFF0, 32'd0, 32'd5, 16'h0, 1'b0, 3'd6, 3'd6, 3'd5,
            1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'(s));
      runOp("R9 max", 32'hFFFF_FFF0, 32'd0, 32'd5, 16'h0, 1'b0, 3'd6, 3'd6, 3'd6,
            1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'(s));
    end
    // R10: pass-through
    runOp("R10 pass", 32'h0102_0304, 32'h1000_0000, 32'hFFFF_FFFF, 16'h0, 1'b0, 3'd6, 3'd6, 3'd7,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R11: invalid selectors
    runOp("R11 invalid A", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 3'd7, 3'd6, 3'd4,
          1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    runOp("R11 invalid B", 32'd1, 32'd1, 32'h1, 16'h0, 1'b0, 3'd6, 3'd7, 3'd7,
          1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    // R12: hold while idle
    idleCheck("R12 hold after invalid");
    runOp("R12 load", 32'd5, 32'd6, 32'h0, 16'h0, 1'b0, 3'd6, 3'd6, 3'd7,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    idleCheck("R12 hold");

    // Random mix covering R1 to R11
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] sa, sb;
      sa = ($urandom_range(0, 15) == 0) ? 3'd7 : 3'($urandom_range(0, 6));
      sb = ($urandom_range(0, 15) == 0) ? 3'd7 : 3'($urandom_range(0, 6));
      runOp("R1..R11 random", $urandom, $urandom, $urandom, 16'($urandom), 1'($urandom_range(0, 3) == 0),
            sa, sb, 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom));
      if (i % 50 == 0) idleCheck("R12 random hold");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule